// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a first-level data cache controller for word loads and stores on a 32-bit byte address space. It holds eight sets, each one block of four 32-bit words (16 bytes). A processor presents one request at a time with a valid/ready handshake and gets a one-cycle response pulse, with the loaded word on loads. Every access first reads the selected set's tag, valid bit, dirty bit and data block in parallel. A hit is served from the cache.

The cache writes back. A store hit changes only the cached block and marks it dirty. On a miss, a dirty victim is written to the next level as a whole block before the new block is requested. The refilled block is then installed and the pending access completes against it. The next-level port moves complete blocks at block-aligned addresses with a request/acknowledge handshake.

Top module: `wb_dcache`

## Requirements
- R1: Synchronous active-high reset leaves every set invalid and clean. After reset `cpu_ready` is 1 and `mem_req` and `cpu_resp_valid` are 0. After reset, a load to a block that was dirty before reset misses with a single read transfer and no write transfer.
- R2: Address fields are as follows. Bits [3:0] are the byte offset within the block, bits [3:2] select the word, bits [6:4] select the set and bits [31:7] form the tag. Bits [1:0] are ignored. A load hit returns the addressed word with `cpu_resp_valid` exactly 2 cycles after the accepting clock edge, and issues no next-level transfer.
- R3: A store takes a tag-check cycle and is then written only on a hit. Its response comes 2 cycles after acceptance with no next-level transfer. A later load of that word returns the stored value.
- R4: A miss whose victim is invalid or clean issues exactly one read transfer (`mem_we`=0) at address {tag, set, 4'b0000}. A load miss then returns the addressed word of the refilled block.
- R5: A miss whose victim is valid and dirty first issues a write transfer (`mem_we`=1) of the victim block at {victim tag, set, 4'b0000}. The read transfer for the new block follows.
- R6: A store miss refills the block and then merges the store word into it. The block becomes dirty, so its later eviction writes back the merged block.
- R7: A block refilled for a load is clean, and its eviction issues no write transfer.
- R8: `cpu_ready` is 0 from the accepting edge until the response, including the whole miss sequence. No response is given while a next-level transfer is pending.
- R9: `mem_req` stays 1 with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle `mem_ack` is 1. The cycle `mem_ack` is 1 ends that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller idle and accepting a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with the pulse on loads |
| mem_req | output | 1 | Next-level transfer pending |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 32 | Block-aligned next-level address |
| mem_wdata | output | 128 | Victim block, word 0 in the low bits |
| mem_rdata | input | 128 | Refill block, sampled with the acknowledge |
| mem_ack | input | 1 | Transfer complete for one cycle |

## Verification
The hardest case to reach is an eviction of a dirty block that got dirty through a store miss. It needs a store to a block that is not in the cache, a refill, a merge, and then a conflicting access to the same set. The stimulus then has to show that the written-back block reached the next level with the merged word intact. The stimulus table builds this chain with blocks that share set 1, and the memory model logs each transfer's direction and address. A reset in the middle of the run, with a dirty line present, shows that reset discards dirty state: the next access to that line produces a lone read.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WBACK  = 2'd2,
    ST_REFILL = 2'd3
  } dc_state_t;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  drt_q;

  // tag RAM: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // state bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      drt_q    <= '0;
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else begin
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        drt_q[wr_idx] <= wr_dirty;
      end
      if (rd_en) begin
        rd_valid <= vld_q[rd_idx];
        rd_dirty <= drt_q[rd_idx];
      end
    end
  end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int SETS  = 8,
  parameter int BLK_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BLK_W-1:0] rd_blk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] wr_blk
);
  logic [BLK_W-1:0] blk_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) blk_mem[wr_idx] <= wr_blk;
    if (rd_en) rd_blk <= blk_mem[rd_idx];
  end
endmodule

// File: rtl/dc_word_merge.sv
module dc_word_merge #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int SEL_W = $clog2(BLK_WORDS),
  localparam int BLK_W = WORD_W * BLK_WORDS
) (
  input  logic [BLK_W-1:0]  base,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] word,
  output logic [BLK_W-1:0]  merged
);
  for (genvar w = 0; w < BLK_WORDS; w++) begin : g_lane
    assign merged[w*WORD_W +: WORD_W] =
      (en && sel == SEL_W'(w)) ? word : base[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4,
  localparam int BLK_W  = WORD_W * BLK_WORDS,
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = $clog2(BLK_WORDS),
  localparam int OFF_W  = BOFF_W + WSEL_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_resp_valid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ack,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              wr_dirty,
  output logic [BLK_W-1:0]  mrg_base,
  output logic              mrg_en,
  output logic [WSEL_W-1:0] mrg_sel,
  output logic [WORD_W-1:0] mrg_word
);
  dc_state_t         st;
  logic [ADDR_W-1:0] q_addr;
  logic              q_we;
  logic [WORD_W-1:0] q_wdata;

  logic [TAG_W-1:0]  q_tag;
  logic [IDX_W-1:0]  q_idx;
  logic [WSEL_W-1:0] q_wsel;
  logic              hit;

  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_wsel = q_addr[BOFF_W +: WSEL_W];
  assign hit    = rd_valid && (rd_tag == q_tag);

  function automatic logic [WORD_W-1:0] pick(input logic [BLK_W-1:0] b,
                                             input logic [WSEL_W-1:0] s);
    return b[int'(s)*WORD_W +: WORD_W];
  endfunction

  assign cpu_ready = (st == ST_IDLE);
  assign rd_en     = (st == ST_IDLE) && cpu_valid;
  assign rd_idx    = cpu_addr[OFF_W +: IDX_W];

  assign wr_idx   = q_idx;
  assign wr_tag   = q_tag;
  assign wr_dirty = q_we;
  assign mrg_en   = q_we;
  assign mrg_sel  = q_wsel;
  assign mrg_word = q_wdata;

  // array write strobe: store hit after the tag check, or any refill
  always_comb begin
    wr_en    = 1'b0;
    mrg_base = rd_blk;
    if (st == ST_LOOKUP && hit && q_we) begin
      wr_en = 1'b1;
    end else if (st == ST_REFILL && mem_ack) begin
      wr_en    = 1'b1;
      mrg_base = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      q_addr         <= '0;
      q_we           <= 1'b0;
      q_wdata        <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_rdata      <= '0;
      mem_req        <= 1'b0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cpu_valid) begin
            q_addr  <= cpu_addr;
            q_we    <= cpu_we;
            q_wdata <= cpu_wdata;
            st      <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            cpu_resp_valid <= 1'b1;
            if (!q_we) cpu_rdata <= pick(rd_blk, q_wsel);
            st <= ST_IDLE;
          end else if (rd_valid && rd_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {rd_tag, q_idx, {OFF_W{1'b0}}};
            mem_wdata <= rd_blk;
            st        <= ST_WBACK;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {q_tag, q_idx, {OFF_W{1'b0}}};
            st       <= ST_REFILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {q_tag, q_idx, {OFF_W{1'b0}}};
            st       <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_ack) begin
            mem_req        <= 1'b0;
            cpu_resp_valid <= 1'b1;
            if (!q_we) cpu_rdata <= pick(mem_rdata, q_wsel);
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4,
  localparam int BLK_W  = WORD_W * BLK_WORDS,
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = $clog2(BLK_WORDS),
  localparam int OFF_W  = BOFF_W + WSEL_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_resp_valid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic              rd_dirty;
  logic [BLK_W-1:0]  rd_blk;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic              wr_dirty;
  logic [BLK_W-1:0]  mrg_base;
  logic              mrg_en;
  logic [WSEL_W-1:0] mrg_sel;
  logic [WORD_W-1:0] mrg_word;
  logic [BLK_W-1:0]  mrg_blk;

  dc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SETS(SETS), .BLK_WORDS(BLK_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .rd_dirty(rd_dirty), .rd_blk(rd_blk),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_dirty(wr_dirty),
    .mrg_base(mrg_base), .mrg_en(mrg_en), .mrg_sel(mrg_sel), .mrg_word(mrg_word)
  );

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_dirty(wr_dirty)
  );

  dc_data_store #(.SETS(SETS), .BLK_W(BLK_W)) u_data (
    .clk(clk),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_blk(rd_blk),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_blk(mrg_blk)
  );

  dc_word_merge #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_merge (
    .base(mrg_base), .en(mrg_en), .sel(mrg_sel), .word(mrg_word),
    .merged(mrg_blk)
  );
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 128,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BLK_W-1:0]  mem_wdata
);
  // R1: first cycle out of reset is idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_ready && !mem_req && !cpu_resp_valid));

  // R4: next-level addresses are block aligned
  assert_block_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  // R5: an acknowledged write-back is followed by the refill read
  assert_wb_then_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R8: the processor is stalled while the next level is busy
  assert_stall_on_mem_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R8: no completion while a transfer is pending
  assert_no_resp_in_miss_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> !mem_req);

  // R9: request fields hold until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

bind wb_dcache dc_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_wb_dcache.sv
module sim_wb_dcache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_ready;
  logic         cpu_resp_valid;
  logic [31:0]  cpu_rdata;
  logic         mem_req;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata;
  logic         mem_ack;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wb_dcache u0 (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // next-level model: 64 blocks, word w of block b starts as A000_0000 + b*16 + w
  logic [127:0] mem [64];
  logic         inited = 1'b0;
  int           cnt = 0;
  int           nops = 0;
  logic         op_we [256];
  logic [31:0]  op_addr [256];

  always @(posedge clk) begin
    if (!inited) begin
      for (int b = 0; b < 64; b++)
        for (int w = 0; w < 4; w++)
          mem[b][w*32 +: 32] <= 32'hA000_0000 + 32'(b*16 + w);
      inited <= 1'b1;
    end
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (cnt >= 1 + (nops % 3)) begin
          mem_ack <= 1'b1;
          cnt     <= 0;
          if (mem_we) mem[mem_addr[9:4]] <= mem_wdata;
          else        mem_rdata <= mem[mem_addr[9:4]];
          op_we[nops % 256]   <= mem_we;
          op_addr[nops % 256] <= mem_addr;
          nops <= nops + 1;
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; ops==0 means a hit, wb is the expected write-back address
  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [31:0] wdata, input logic [31:0] exp,
                        input int ops, input logic [31:0] wb, input string req);
    int  base;
    int  lat;
    bit  ready_bad;
    base = nops;
    ready_bad = 1'b0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    lat = 1;
    while (!cpu_resp_valid && lat < 200) begin
      if (cpu_ready) ready_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    chk(!ready_bad, "R8 ready low until response", 32'(ready_bad), 0);
    chk(nops - base == ops, {req, " transfer count"}, 32'(nops - base), 32'(ops));
    if (!we) chk(cpu_rdata == exp, {req, " load data"}, cpu_rdata, exp);
    if (ops == 0) begin
      chk(lat == 2, {req, " hit latency"}, 32'(lat), 2);
    end else if (ops == 1 && nops - base == 1) begin
      chk(op_we[base % 256] == 1'b0 && op_addr[base % 256] == {addr[31:4], 4'h0},
          "R4 refill read addr", op_addr[base % 256], {addr[31:4], 4'h0});
    end else if (ops == 2 && nops - base == 2) begin
      chk(op_we[base % 256] == 1'b1 && op_addr[base % 256] == wb,
          "R5 write-back first", op_addr[base % 256], wb);
      chk(op_we[(base+1) % 256] == 1'b0 &&
          op_addr[(base+1) % 256] == {addr[31:4], 4'h0},
          "R5 read after write-back", op_addr[(base+1) % 256], {addr[31:4], 4'h0});
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [1:0]  ops;
    logic [31:0] wb;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h004, 32'h0,         32'hA000_0001, 2'd1, 32'h0},   // R4 cold miss
    '{1'b0, 32'h00C, 32'h0,         32'hA000_0003, 2'd0, 32'h0},   // R2 hit, word 3
    '{1'b1, 32'h008, 32'h1111_1111, 32'h0,         2'd0, 32'h0},   // R3 store hit
    '{1'b0, 32'h008, 32'h0,         32'h1111_1111, 2'd0, 32'h0},   // R3 read back
    '{1'b0, 32'h084, 32'h0,         32'hA000_0081, 2'd2, 32'h000}, // R5 dirty victim
    '{1'b0, 32'h008, 32'h0,         32'h1111_1111, 2'd1, 32'h0},   // R7 clean victim
    '{1'b1, 32'h114, 32'h2222_2222, 32'h0,         2'd1, 32'h0},   // R6 store miss
    '{1'b0, 32'h114, 32'h0,         32'h2222_2222, 2'd0, 32'h0},   // R6 merged word
    '{1'b0, 32'h118, 32'h0,         32'hA000_0112, 2'd0, 32'h0},   // R6 rest of block
    '{1'b0, 32'h070, 32'h0,         32'hA000_0070, 2'd1, 32'h0},   // R2 set 7
    '{1'b0, 32'h0F4, 32'h0,         32'hA000_00F1, 2'd1, 32'h0},   // R7 conflict
    '{1'b0, 32'h01C, 32'h0,         32'hA000_0013, 2'd2, 32'h110}, // R6 dirty via miss
    '{1'b0, 32'h110, 32'h0,         32'hA000_0110, 2'd1, 32'h0},   // R6 block written
    '{1'b0, 32'h117, 32'h0,         32'h2222_2222, 2'd0, 32'h0}    // R2 low bits ignored
  };

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(cpu_ready && !mem_req && !cpu_resp_valid, "R1 reset state",
        {29'd0, cpu_ready, mem_req, cpu_resp_valid}, 32'h4);

    for (int i = 0; i < NVEC; i++)
      access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].exp,
             int'(VEC[i].ops), VEC[i].wb, $sformatf("R2 vec%0d", i));

    // R1: dirty line discarded by reset
    access(1'b1, 32'h114, 32'h3333_3333, 32'h0, 0, 32'h0, "R3 store hit before reset");
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(cpu_ready && !mem_req && !cpu_resp_valid, "R1 state after reset",
        {29'd0, cpu_ready, mem_req, cpu_resp_valid}, 32'h4);
    access(1'b0, 32'h114, 32'h0, 32'h2222_2222, 1, 32'h0, "R1 invalid and clean");

    // R6/R5: store miss on clean victim, then evicted dirty
    access(1'b1, 32'h198, 32'h4444_4444, 32'h0, 1, 32'h0, "R6 store miss clean victim");
    access(1'b0, 32'h01C, 32'h0, 32'hA000_0013, 2, 32'h190, "R5 evict merged block");
    access(1'b0, 32'h198, 32'h0, 32'h4444_4444, 1, 32'h0, "R6 merged word persisted");
    access(1'b0, 32'h194, 32'h0, 32'hA000_0191, 0, 32'h0, "R2 neighbour word hit");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule